// File: doc/BRIEF.md
# Pulse-Swallow Programmable RF Divider

This block is the programmable feedback divider of a frequency synthesiser loop. It runs on the output clock of an external dual-modulus prescaler that divides the RF signal by 16 or by 17. It drives that prescaler's modulus line so that the RF signal is divided by N = 16·M + A overall. M is a 13-bit main count and A is a 4-bit swallow count, and together they form a 17-bit ratio word. Within each output period the swallow counter holds the prescaler at divide-by-17 for A prescaler cycles, and the main counter closes the period after M prescaler cycles. The RF input therefore sees 17·A + 16·(M − A) = N cycles per output pulse.

A new ratio is accepted only at the end of a period, and only when the control side flags it as pending. An output period is therefore never shortened or stretched by a write. Ratios below 240 are raised to 240, so the swallow count can never exceed the main count. The divided pulse feeds the phase detector. A strobe in the same cycle tells the control side that the new setting has been taken. A toggling copy at half the output rate is provided for routing to a test pin.

Top module: `swallow_divider`

## Requirements
- R1: Each output period lasts exactly M prescaler clocks, where M is bits 16:4 of the accepted ratio word.
- R2: `mod_sel` is 1 (divide-by-17) in the first A clocks of each period and 0 for the remaining M − A clocks, where A is bits 3:0 of the accepted ratio word. It never rises again inside a period.
- R3: `fpd_pulse` is high for exactly one clock, the last clock of each period, and `cycle_done` is high in that same clock and in no other.
- R4: A ratio word below 240, including 0, is treated as 240 (M = 15, A = 0).
- R5: When `reload_req` is 1 in the last clock of a period, the `ratio_word` present in that clock sets the next period and all later ones.
- R6: Changes of `ratio_word`, and `reload_req` pulses in any clock other than the last one of a period, have no effect on the current or following periods.
- R7: `fpd_half` is 0 after reset and toggles in the clock after each `fpd_pulse`.
- R8: While `rst_n` is 0 at a clock edge, `mod_sel`, `fpd_pulse` and `cycle_done` are 0 and the counters load `ratio_word`. The first period after release has the full length given by that word.
- R9: The largest ratio, 131071 (M = 8191, A = 15), gives an 8191-clock period with 15 divide-by-17 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pre | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_word | input | 17 | Requested ratio N, M in bits 16:4, A in bits 3:0 |
| reload_req | input | 1 | A new ratio is pending and may be taken at the period end |
| mod_sel | output | 1 | Prescaler modulus: 1 selects divide-by-17, 0 divide-by-16 |
| fpd_pulse | output | 1 | One-clock divided output pulse for the phase detector |
| cycle_done | output | 1 | Period-end strobe for the control side |
| fpd_half | output | 1 | Divided output halved again, for test routing |

## Verification
The bench builds the divider with its default parameters: a 13-bit main count, a 4-bit swallow count and a floor of 240. With these, the smallest period (15 clocks, with the swallow count at 0 or at its maximum of 15) and the largest (8191 clocks) both fit in one short run. A scoreboard queue holds, for each coming period, the expected length and divide-by-17 count. These are derived from the word and the reload timing the bench drives. A monitor matches every observed pulse against the queue. Clamped words, a mid-period write, and the reload handoff at the period end are each covered by their own period.

// File: rtl/swallow_pkg.sv
// Shared default dimensions for the pulse-swallow divider.
// Assumes: main counter width plus swallow width equals the ratio word width.
package swallow_pkg;
    localparam int DEF_M_W       = 13;   // main (M) counter width
    localparam int DEF_A_W       = 4;    // swallow (A) counter width
    localparam int DEF_MIN_RATIO = 240;  // smallest ratio that keeps M >= A
endpackage

// File: rtl/ratio_latch.sv
// Active-ratio holder: clamps the requested word to the legal floor and
// chooses the value the counters load at reset or at a period end.
// Assumes: term is high only in the last clock of a period.
module ratio_latch #(
    parameter int M_W       = swallow_pkg::DEF_M_W,
    parameter int A_W       = swallow_pkg::DEF_A_W,
    parameter int MIN_RATIO = swallow_pkg::DEF_MIN_RATIO
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [M_W+A_W-1:0] word,
    input  logic               req,
    input  logic               term,
    output logic [M_W-1:0]     load_m,
    output logic [A_W-1:0]     load_a
);
    localparam int N_W = M_W + A_W;

    logic [N_W-1:0] clamped;
    logic [N_W-1:0] sel;
    logic [M_W-1:0] act_m;
    logic [A_W-1:0] act_a;

    // Raise any word below the floor up to the floor.
    always_comb begin
        if (word < N_W'(MIN_RATIO)) clamped = N_W'(MIN_RATIO);
        else                        clamped = word;
    end

    // Take the request during reset or when flagged; otherwise repeat the active ratio.
    always_comb begin
        if (!rst_n || req) sel = clamped;
        else               sel = {act_m, act_a};
    end

    assign load_m = sel[N_W-1:A_W];
    assign load_a = sel[A_W-1:0];

    // Commit the chosen ratio only at reset or at a period end.
    always_ff @(posedge clk) begin
        if (!rst_n || term) begin
            act_m <= sel[N_W-1:A_W];
            act_a <= sel[A_W-1:0];
        end
    end

    // Active ratio must not move inside a period (R6).
    assert_ratio_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !term |=> ($stable(act_m) && $stable(act_a)));
endmodule

// File: rtl/swallow_ctr.sv
// Main and swallow down-counters. The main count spans the period and the
// swallow count holds the modulus line at divide-by-17 until it empties.
// Assumes: load_m >= 15 and load_m >= load_a (guaranteed by the clamp).
module swallow_ctr #(
    parameter int M_W = swallow_pkg::DEF_M_W,
    parameter int A_W = swallow_pkg::DEF_A_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [M_W-1:0] load_m,
    input  logic [A_W-1:0] load_a,
    output logic           term,
    output logic           mod17
);
    logic [M_W-1:0] m_cnt;
    logic [A_W-1:0] a_cnt;

    assign term  = (m_cnt == '0);
    assign mod17 = (a_cnt != '0) && rst_n;

    // Reload both counters at reset or at a period end, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n || term) begin
            m_cnt <= load_m - M_W'(1);
            a_cnt <= load_a;
        end else begin
            m_cnt <= m_cnt - M_W'(1);
            if (a_cnt != '0) a_cnt <= a_cnt - A_W'(1);
        end
    end

    // The period end lasts a single clock (R3).
    assert_term_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        term |=> !term);
    // Divide-by-17 only starts a period, never resumes mid-period (R2).
    assert_mod_no_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod17) |-> ($past(term) || !$past(rst_n)));
endmodule

// File: rtl/half_div.sv
// Toggle stage producing the divided output halved, for a test pin.
// Assumes: pulse is a one-clock strobe.
module half_div (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    output logic half
);
    // Flip once per divided pulse; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     half <= 1'b0;
        else if (pulse) half <= ~half;
    end

    // Every pulse flips the halved output (R7).
    assert_half_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> (half != $past(half)));
endmodule

// File: rtl/swallow_divider.sv
// Top of the pulse-swallow divider: clamps and latches the ratio, runs
// the M/A counters, and drives modulus, pulse, strobe and halved output.
// Assumes: clk_pre is the prescaler output; one clock = one prescaler cycle.
module swallow_divider #(
    parameter int M_W       = swallow_pkg::DEF_M_W,
    parameter int A_W       = swallow_pkg::DEF_A_W,
    parameter int MIN_RATIO = swallow_pkg::DEF_MIN_RATIO
) (
    input  logic               clk_pre,
    input  logic               rst_n,
    input  logic [M_W+A_W-1:0] ratio_word,
    input  logic               reload_req,
    output logic               mod_sel,
    output logic               fpd_pulse,
    output logic               cycle_done,
    output logic               fpd_half
);
    logic [M_W-1:0] load_m;
    logic [A_W-1:0] load_a;
    logic           term;
    logic           mod17;

    ratio_latch #(.M_W(M_W), .A_W(A_W), .MIN_RATIO(MIN_RATIO)) u_latch (
        .clk(clk_pre), .rst_n(rst_n), .word(ratio_word), .req(reload_req),
        .term(term), .load_m(load_m), .load_a(load_a));

    swallow_ctr #(.M_W(M_W), .A_W(A_W)) u_ctr (
        .clk(clk_pre), .rst_n(rst_n), .load_m(load_m), .load_a(load_a),
        .term(term), .mod17(mod17));

    assign mod_sel    = mod17;
    assign fpd_pulse  = term && rst_n;
    assign cycle_done = term && rst_n;

    half_div u_half (
        .clk(clk_pre), .rst_n(rst_n), .pulse(fpd_pulse), .half(fpd_half));

    // Modulus is held at divide-by-16 in reset (R8).
    always_comb begin
        if (!rst_n) assert_reset_mod16_R8: assert (!mod_sel);
    end
endmodule

// File: tb/test_swallow_divider.sv
module test_swallow_divider;
    localparam int CLK_PERIOD = 10;

    typedef struct { int m; int a; string tag; } exp_t;

    logic        clk_pre = 1'b0;
    logic        rst_n   = 1'b0;
    logic [16:0] ratio_word = '0;
    logic        reload_req = 1'b0;
    logic        mod_sel, fpd_pulse, cycle_done, fpd_half;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    int   act_w;
    exp_t q[$];

    int   len = 0, mcount = 0, exp_half = 0;
    bit   seen_low = 1'b0;

    swallow_divider i_swallow_divider (
        .clk_pre(clk_pre), .rst_n(rst_n), .ratio_word(ratio_word),
        .reload_req(reload_req), .mod_sel(mod_sel), .fpd_pulse(fpd_pulse),
        .cycle_done(cycle_done), .fpd_half(fpd_half));

    always #(CLK_PERIOD/2) clk_pre = ~clk_pre;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic exp_t mk(input int w, input string tag);
        exp_t e;
        int n;
        n = (w < 240) ? 240 : w;   // R4 floor
        e.m = n >> 4;
        e.a = n & 15;
        e.tag = tag;
        return e;
    endfunction

    // Monitor: compares each observed period with the scoreboard head.
    always @(negedge clk_pre) begin
        if (rst_n && !done) begin
            len++;
            if (mod_sel) begin
                if (seen_low) check(1'b0, "R2 mod rise mid-period", 1, 0);
                mcount++;
            end else begin
                seen_low = 1'b1;
            end
            if (cycle_done != fpd_pulse)
                check(1'b0, "R3 strobe vs pulse", int'(cycle_done), int'(fpd_pulse));
            if (fpd_pulse) begin
                if (q.size() == 0) begin
                    check(1'b0, "R1 unexpected pulse", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(len == e.m,    {e.tag, " R1 period length"}, len, e.m);
                    check(mcount == e.a, {e.tag, " R2 div17 count"}, mcount, e.a);
                    check(int'(fpd_half) == exp_half, {e.tag, " R7 half"}, int'(fpd_half), exp_half);
                    check(cycle_done == 1'b1, {e.tag, " R3 strobe"}, int'(cycle_done), 1);
                end
                exp_half ^= 1;
                len = 0; mcount = 0; seen_low = 1'b0;
            end
        end
    end

    task automatic wait_pulse();
        do @(negedge clk_pre); while (!fpd_pulse);
    endtask

    // Driver: hand a new ratio over at the period end (R5).
    task automatic retune(input int w, input string tag);
        wait_pulse();
        ratio_word = 17'(w);
        reload_req = 1'b1;
        act_w = w;
        q.push_back(mk(w, tag));
        @(negedge clk_pre);
        reload_req = 1'b0;
    endtask

    task automatic keep(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            wait_pulse();
            q.push_back(mk(act_w, tag));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk_pre);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        ratio_word = 17'd1000;   // M=62, A=8
        act_w = 1000;
        repeat (3) @(posedge clk_pre);
        @(negedge clk_pre);
        check(!mod_sel,    "R8 reset mod_sel",    int'(mod_sel), 0);
        check(!fpd_pulse,  "R8 reset fpd_pulse",  int'(fpd_pulse), 0);
        check(!cycle_done, "R8 reset cycle_done", int'(cycle_done), 0);
        check(!fpd_half,   "R7 reset fpd_half",   int'(fpd_half), 0);
        q.push_back(mk(1000, "R8"));
        @(posedge clk_pre);
        #1 rst_n = 1'b1;

        keep(2, "R1");
        retune(255, "R2");          // M=15, A=15: div17 whole period
        keep(1, "R2");
        retune(100, "R4");          // clamped to 240
        retune(0, "R4");            // clamped to 240
        retune(240, "R4");
        retune(4103, "R5");         // M=256, A=7

        // R6: mid-period word change and reload pulse are ignored
        wait_pulse();
        q.push_back(mk(act_w, "R6"));
        @(negedge clk_pre);
        @(negedge clk_pre);
        ratio_word = 17'd3000;
        reload_req = 1'b1;
        @(negedge clk_pre);
        reload_req = 1'b0;
        keep(1, "R6");

        retune(131071, "R9");       // M=8191, A=15
        retune(335, "R5");          // M=20, A=15
        keep(1, "R5");
        wait_pulse();
        @(negedge clk_pre);
        check(q.size() == 0, "R1 scoreboard drained", q.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule